// File: doc/BRIEF.md
# Programmable baud clock generator

This block derives a sixteen-times bit-rate clock for a serial receiver/transmitter from a single master clock. A 4-bit select code chooses one of fourteen internal rates, or one of two codes that pass an external multiplex input straight to the rate output. The master clock comes from one of two pins, the crystal-side input or the external clock pin, according to a source-enable input.

All logic runs on the system clock `clk`. The two master-clock pins, the source enable and the other inputs are sampled on `clk`, and each rising edge of the selected master clock advances the counters by one step. A power-of-two prescaler divides the master clock by `PRE_DIV`. Its three lowest binary stages and the buffered master clock are brought out, so that external logic can scan several channels. A bank of dividers counts prescaler half-periods to produce each rate. The 1800 baud rate uses a repeating 5, 5, 6 period pattern to reach its fractional divide.

A differentiator on the external clock pin clears every counter during the first high level of that pin after the source enable falls. Holding that pin high while the crystal input is selected keeps the counters cleared for as long as it stays high.

Top module: `baud_rate_gen`

## Requirements
- R1: `mclk_out` equals the level of `xtal_in` when `use_xtal` is 1 and the level of `ext_clk` when `use_xtal` is 0, two `clk` cycles after those inputs change.
- R2: `tap_out` is a 3-bit binary count of master-clock rising edges modulo 8 (bit 0 divides the master clock by 2, bit 2 divides it by 8). It updates within three `clk` cycles of each edge and holds between edges.
- R3: For select codes 2 to 15 except 10, `rate_out` is a square wave with a period of D x `PRE_DIV` master edges and equal high and low halves. D is 192, 128, 71, 48, 16, 4, 1, 2, -, 8, 4, 32, 64 and 87 for codes 2 to 15 in turn. The halves begin low after a counter clear.
- R4: Select code 10 (1800 baud) repeats three periods of 5, 5 and 6 prescaled periods, each period low for its first half and high for its second half, starting from a clear. The three periods together span exactly 16 x `PRE_DIV` master edges.
- R5: With select code 0 or 1, `rate_out` equals `mux_in` as it was sampled at the latest master rising edge. A change of `mux_in` without a master edge does not reach `rate_out`, and a static `mux_in` gives a static output.
- R6: When `tap_out[2]` is looped back into `mux_in` under select code 0, `rate_out` has a period of 8 master edges with halves of 4 edges.
- R7: While `use_xtal` is 1 and `ext_clk` is 1, all counters stay cleared: `tap_out` is 0 and the divided `rate_out` is 0, whatever `xtal_in` does. Counting resumes on the first master edge after `ext_clk` returns low.
- R8: After `use_xtal` falls, the first high level on `ext_clk` clears all counters, and its own rising edge is not counted. Later `ext_clk` rising edges count normally.
- R9: `rate_sel` is sampled only on a master rising edge. A new code selects the new divider at that edge without clearing any counter, and a code change with no master edge leaves `rate_out` unchanged.
- R10: While `rst_n` is low and right after its release, `rate_out`, `tap_out` and `mclk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_xtal | input | 1 | Source enable: 1 selects `xtal_in`, 0 selects `ext_clk` |
| xtal_in | input | 1 | Crystal-side master clock level |
| ext_clk | input | 1 | External master clock level and initialization pin |
| rate_sel | input | 4 | Rate select code |
| mux_in | input | 1 | External multiplex input for codes 0 and 1 |
| mclk_out | output | 1 | Buffered selected master clock |
| tap_out | output | 3 | Prescaler stages: divide by 2, 4 and 8 |
| rate_out | output | 1 | Selected sixteen-times rate clock |

## Verification
The bench builds the block with `PRE_DIV` set to 8 instead of 16. This halves every rate period, so every code can be measured over a full period from a clear, including the slow 50 and 110 baud dividers and the odd 71 and 87 divisors, while the three tap stages remain a complete 3-bit count. With this value the divide-by-8 tap equals one prescaler period, so the loop-back case and the 9600 code share a period, and both are checked against their own expected widths. The fractional pattern, the two reset paths and the edge-timed select change are each reached by clearing the counters first and then counting master edges.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_CODES = 1 << CODE_W;
  localparam int unsigned TAP_W     = 3;

  // fractional rate: periods of FRAC_SHORT, FRAC_SHORT, FRAC_LONG
  localparam logic [CODE_W-1:0] FRAC_CODE  = 4'd10;
  localparam int unsigned FRAC_SHORT     = 5;
  localparam int unsigned FRAC_LONG      = 6;
  localparam int unsigned FRAC_HALVES    = 6;
  localparam int unsigned FRAC_LONG_FROM = 4;

  typedef logic [CODE_W-1:0] rate_code_t;

  // codes that route the external multiplex input
  function automatic logic is_passthru(input rate_code_t code);
    return code[CODE_W-1:1] == '0;
  endfunction

  // divisor in prescaled periods; also the half-period in prescaler half ticks
  function automatic int unsigned rate_divisor(input int unsigned code);
    case (code)
      2:       return 192;
      3:       return 128;
      4:       return 71;
      5:       return 48;
      6:       return 16;
      7:       return 4;
      8:       return 1;
      9:       return 2;
      11:      return 8;
      12:      return 4;
      13:      return 32;
      14:      return 64;
      15:      return 87;
      default: return 1;
    endcase
  endfunction

  // half-period, in half ticks, of the fractional divider at a given phase
  function automatic int unsigned frac_half_len(input int unsigned phase);
    return (phase >= FRAC_LONG_FROM) ? FRAC_LONG : FRAC_SHORT;
  endfunction

endpackage

// File: rtl/baud_clk_front.sv
module baud_clk_front (
  input  logic clk,
  input  logic rst_n,
  input  logic use_xtal,
  input  logic xtal_in,
  input  logic ext_clk,
  output logic mclk_lvl_o,
  output logic mclk_rise_o,
  output logic init_clear_o
);

  logic xtal_q, ext_q, use_q, ext_prev, lvl_q, armed;
  logic lvl;
  logic ext_fell;

  assign lvl      = use_q ? xtal_q : ext_q;
  assign ext_fell = ext_prev & ~ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q   <= 1'b0;
      ext_q    <= 1'b0;
      use_q    <= 1'b0;
      ext_prev <= 1'b0;
      lvl_q    <= 1'b0;
      armed    <= 1'b1;
    end else begin
      xtal_q   <= xtal_in;
      ext_q    <= ext_clk;
      use_q    <= use_xtal;
      ext_prev <= ext_q;
      lvl_q    <= lvl;
      // armed while the crystal is selected; disarmed once the first
      // external high level has ended
      if (use_q)         armed <= 1'b1;
      else if (ext_fell) armed <= 1'b0;
    end
  end

  assign mclk_lvl_o   = lvl_q;
  assign mclk_rise_o  = lvl & ~lvl_q;
  assign init_clear_o = ext_q & (use_q | armed);

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_DIV = 16,
  localparam int unsigned PRE_W  = $clog2(PRE_DIV)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          step,
  output logic [baud_pkg::TAP_W-1:0]    tap_o,
  output logic                          half_tick_o
);

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign tap_o       = cnt[baud_pkg::TAP_W-1:0];
  // a half tick closes every PRE_DIV/2 master edges
  assign half_tick_o = step & ~clear & (&cnt[PRE_W-2:0]);

endmodule

// File: rtl/baud_int_div.sv
module baud_int_div #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic wave_o
);

  logic [W-1:0] cnt;
  logic         last;

  assign last = (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wave_o <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      wave_o <= 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt    <= '0;
        wave_o <= ~wave_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic wave_o
);
  import baud_pkg::*;

  localparam int unsigned W  = $clog2(FRAC_LONG + 1);
  localparam int unsigned PW = $clog2(FRAC_HALVES);

  logic [W-1:0]  cnt;
  logic [PW-1:0] phase;
  logic [W-1:0]  half_len;
  logic          last;

  assign half_len = W'(frac_half_len(int'(phase)));
  assign last     = (cnt == half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= '0;
      wave_o <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      phase  <= '0;
      wave_o <= 1'b0;
    end else if (tick) begin
      if (last) begin
        cnt    <= '0;
        wave_o <= ~wave_o;
        phase  <= (phase == PW'(FRAC_HALVES - 1)) ? '0 : phase + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_xtal,
  input  logic       xtal_in,
  input  logic       ext_clk,
  input  logic [3:0] rate_sel,
  input  logic       mux_in,
  output logic       mclk_out,
  output logic [2:0] tap_out,
  output logic       rate_out
);
  import baud_pkg::*;

  // named internal events, observed by the bound checker
  logic                 mclk_rise;
  logic                 init_clear;
  logic                 step;
  logic                 half_tick;
  rate_code_t           sel_q;
  logic                 mux_q;
  logic [NUM_CODES-1:0] div_bus;
  logic                 rate_next;

  baud_clk_front front_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .use_xtal     (use_xtal),
    .xtal_in      (xtal_in),
    .ext_clk      (ext_clk),
    .mclk_lvl_o   (mclk_out),
    .mclk_rise_o  (mclk_rise),
    .init_clear_o (init_clear)
  );

  assign step = mclk_rise & ~init_clear;

  baud_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (init_clear),
    .step        (step),
    .tap_o       (tap_out),
    .half_tick_o (half_tick)
  );

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_rate
    if (c < 2) begin : g_pass
      assign div_bus[c] = 1'b0;
    end else if (c == int'(FRAC_CODE)) begin : g_frac
      baud_frac_div div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (init_clear),
        .tick   (half_tick),
        .wave_o (div_bus[c])
      );
    end else begin : g_int
      baud_int_div #(.LIMIT(rate_divisor(c))) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (init_clear),
        .tick   (half_tick),
        .wave_o (div_bus[c])
      );
    end
  end

  // select and multiplex input are taken on master edges only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      mux_q <= 1'b0;
    end else if (mclk_rise) begin
      sel_q <= rate_sel;
      mux_q <= mux_in;
    end
  end

  assign rate_next = is_passthru(sel_q) ? mux_q : div_bus[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_out <= 1'b0;
    else        rate_out <= rate_next;
  end

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mclk_rise,
  input logic        half_tick,
  input logic        init_clear,
  input logic [3:0]  sel_q,
  input logic        mux_q,
  input logic [15:0] div_bus,
  input logic [2:0]  tap_out,
  input logic        rate_out
);

  assert_tap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_rise && !init_clear) |=> $stable(tap_out));

  assert_tap_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_rise && !init_clear) |=> (tap_out == $past(tap_out) + 3'd1));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_clear |=> (tap_out == 3'd0 && div_bus == 16'd0));

  assert_div_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !init_clear) |=> $stable(div_bus));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_rise |=> $stable(sel_q));

  assert_mux_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[3:1] == 3'b000) |=> (rate_out == $past(mux_q)));

endmodule

bind baud_rate_gen baud_rate_gen_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mclk_rise  (mclk_rise),
  .half_tick  (half_tick),
  .init_clear (init_clear),
  .sel_q      (sel_q),
  .mux_q      (mux_q),
  .div_bus    (div_bus),
  .tap_out    (tap_out),
  .rate_out   (rate_out)
);

// File: tb/baud_rate_gen_tb_top.sv
`timescale 1ns/1ps
module baud_rate_gen_tb_top;

  localparam int unsigned PRE = 8;
  localparam int          LIM = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       use_xtal = 1'b1;
  logic       xtal_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       mux_man = 1'b0;
  logic       loop_en = 1'b0;
  logic       mux_in;
  logic       mclk_out;
  logic [2:0] tap_out;
  logic       rate_out;

  int checks = 0;
  int errors = 0;

  assign mux_in = loop_en ? tap_out[2] : mux_man;

  always #2.5 clk = ~clk;

  baud_rate_gen #(.PRE_DIV(PRE)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_xtal (use_xtal),
    .xtal_in  (xtal_in),
    .ext_clk  (ext_clk),
    .rate_sel (rate_sel),
    .mux_in   (mux_in),
    .mclk_out (mclk_out),
    .tap_out  (tap_out),
    .rate_out (rate_out)
  );

  // divisor table restated for the bench
  function automatic int exp_div(input int code);
    int t[16] = '{0, 0, 192, 128, 71, 48, 16, 4, 1, 2, 0, 8, 4, 32, 64, 87};
    return t[code];
  endfunction

  function automatic logic pick(input int s);
    if (s == 1) return tap_out[0];
    if (s == 2) return tap_out[2];
    return rate_out;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one master clock period on the selected pin; outputs settled on return
  task automatic mtick();
    if (use_xtal) xtal_in = 1'b1; else ext_clk = 1'b1;
    wait_clk(3);
    if (use_xtal) xtal_in = 1'b0; else ext_clk = 1'b0;
    wait_clk(3);
  endtask

  task automatic mticks(input int n);
    for (int i = 0; i < n; i++) mtick();
  endtask

  task automatic clear_counters();
    use_xtal = 1'b1;
    ext_clk  = 1'b1;
    wait_clk(3);
    ext_clk  = 1'b0;
    wait_clk(3);
  endtask

  task automatic next_change(input int s, output int n);
    logic v;
    v = pick(s);
    n = 0;
    do begin
      mtick();
      n++;
    end while (pick(s) == v && n < LIM);
  endtask

  // align to a rising edge, then measure high and low widths in master edges
  task automatic measure(input int s, output int hi, output int lo);
    int n;
    if (pick(s)) next_change(s, n);
    next_change(s, n);
    next_change(s, hi);
    next_change(s, lo);
  endtask

  task automatic test_reset();
    check(rate_out == 1'b0, "R10 rate_out", int'(rate_out), 0);
    check(tap_out == 3'd0, "R10 tap_out", int'(tap_out), 0);
    check(mclk_out == 1'b0, "R10 mclk_out", int'(mclk_out), 0);
  endtask

  task automatic test_source();
    use_xtal = 1'b1;
    xtal_in  = 1'b1;
    wait_clk(3);
    check(mclk_out == 1'b1, "R1 crystal high", int'(mclk_out), 1);
    use_xtal = 1'b0;
    wait_clk(3);
    check(mclk_out == 1'b0, "R1 external low", int'(mclk_out), 0);
    xtal_in  = 1'b0;
    use_xtal = 1'b1;
    wait_clk(3);
    check(mclk_out == 1'b0, "R1 crystal low", int'(mclk_out), 0);
  endtask

  task automatic test_taps();
    int hi, lo;
    clear_counters();
    mticks(11);
    check(tap_out == 3'd3, "R2 count 11 mod 8", int'(tap_out), 3);
    measure(1, hi, lo);
    check(hi == 1 && lo == 1, "R2 tap0 halves", hi * 100 + lo, 101);
    measure(2, hi, lo);
    check(hi == 4 && lo == 4, "R2 tap2 halves", hi * 100 + lo, 404);
  endtask

  task automatic test_rates();
    int hi, lo, h;
    for (int c = 2; c < 16; c++) begin
      if (c == 10) continue;
      rate_sel = 4'(c);
      clear_counters();
      measure(0, hi, lo);
      h = exp_div(c) * int'(PRE) / 2;
      check(hi == h, $sformatf("R3 code %0d high", c), hi, h);
      check(lo == h, $sformatf("R3 code %0d low", c), lo, h);
    end
  endtask

  task automatic test_frac();
    int lo, hi, sum;
    int pat[3] = '{5, 5, 6};
    rate_sel = 4'd10;
    clear_counters();
    sum = 0;
    for (int p = 0; p < 3; p++) begin
      next_change(0, lo);
      next_change(0, hi);
      sum += lo + hi;
      check(lo == pat[p] * int'(PRE) / 2, $sformatf("R4 period %0d low", p), lo, pat[p] * int'(PRE) / 2);
      check(hi == lo, $sformatf("R4 period %0d duty", p), hi, lo);
    end
    check(sum == 16 * int'(PRE), "R4 three periods", sum, 16 * int'(PRE));
  endtask

  task automatic test_mux();
    rate_sel = 4'd0;
    mux_man  = 1'b1;
    mtick();
    mtick();
    check(rate_out == 1'b1, "R5 code 0 high", int'(rate_out), 1);
    mux_man = 1'b0;
    wait_clk(6);
    check(rate_out == 1'b1, "R5 no edge ignored", int'(rate_out), 1);
    mtick();
    check(rate_out == 1'b0, "R5 code 0 low", int'(rate_out), 0);
    rate_sel = 4'd1;
    mux_man  = 1'b1;
    mtick();
    mtick();
    check(rate_out == 1'b1, "R5 code 1 high", int'(rate_out), 1);
    mticks(5);
    check(rate_out == 1'b1, "R5 static level", int'(rate_out), 1);
    mux_man = 1'b0;
  endtask

  task automatic test_loop();
    int hi, lo;
    rate_sel = 4'd0;
    clear_counters();
    loop_en = 1'b1;
    measure(0, hi, lo);
    loop_en = 1'b0;
    check(hi == 4 && lo == 4, "R6 tap loop halves", hi * 100 + lo, 404);
  endtask

  task automatic test_hold_reset();
    rate_sel = 4'd9;
    clear_counters();
    ext_clk = 1'b1;
    wait_clk(3);
    mticks(10);
    check(tap_out == 3'd0, "R7 taps held", int'(tap_out), 0);
    check(rate_out == 1'b0, "R7 rate held", int'(rate_out), 0);
    ext_clk = 1'b0;
    wait_clk(3);
    mticks(3);
    check(tap_out == 3'd3, "R7 count resumes", int'(tap_out), 3);
  endtask

  task automatic test_first_high();
    clear_counters();
    mticks(3);
    check(tap_out == 3'd3, "R8 before switch", int'(tap_out), 3);
    use_xtal = 1'b0;
    wait_clk(3);
    ext_clk = 1'b1;
    wait_clk(3);
    check(tap_out == 3'd0, "R8 first high clears", int'(tap_out), 0);
    ext_clk = 1'b0;
    wait_clk(3);
    mticks(5);
    check(tap_out == 3'd5, "R8 later edges count", int'(tap_out), 5);
    use_xtal = 1'b1;
    wait_clk(3);
  endtask

  task automatic test_select_change();
    int e;
    rate_sel = 4'd9;
    clear_counters();
    mticks(49);
    e = (49 / (exp_div(9) * int'(PRE) / 2)) % 2;
    check(int'(rate_out) == e, "R9 code 9 after 49", int'(rate_out), e);
    rate_sel = 4'd11;
    wait_clk(6);
    check(int'(rate_out) == e, "R9 no edge no change", int'(rate_out), e);
    mtick();
    e = (50 / (exp_div(11) * int'(PRE) / 2)) % 2;
    check(int'(rate_out) == e, "R9 code 11 after 50", int'(rate_out), e);
    check(tap_out == 3'd2, "R9 counters kept", int'(tap_out), 2);
  endtask

  initial begin
    wait_clk(4);
    test_reset();
    rst_n = 1'b1;
    wait_clk(2);
    test_reset();
    test_source();
    test_taps();
    test_rates();
    test_frac();
    test_mux();
    test_loop();
    test_hold_reset();
    test_first_high();
    test_select_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule